// File: doc/BRIEF.md
# Thermal Threshold Interrupt Controller

This block watches a stream of 8-bit temperature codes from an on-chip sensor. Each accepted sample is compared with a set of programmable rise thresholds and a set of programmable fall thresholds. When the temperature climbs past a rise threshold, or drops under a fall threshold, the block latches a pending bit for that threshold and direction. Pending bits that are also enabled are ORed onto one interrupt line. The interrupt handler reads the pending bits, works out which crossing occurred and clears that bit by writing a one.

Software programs the block through a flat word-addressed register interface with a combinational read path. The interface holds a run bit, an idle flag, a sample-decimation interval, the threshold codes, an enable mask and the pending bits. There are two compile-time choices. The first is the bit layout of the events: packed (one bit per threshold) or spread out (every fourth bit). The second is whether pending bits are cleared through a separate clear address or by writing one-to-clear on the pending address itself.

Top module: `thr_irq_ctrl`

## Requirements
- R1: On an accepted sample, rise event n is recorded if the previous accepted sample was at or below rise threshold n and the current one is strictly above it. Its pending bit becomes visible in the cycle after the sample is accepted.
- R2: On an accepted sample, fall event n is recorded if the previous accepted sample was at or above fall threshold n and the current one is strictly below it.
- R3: An event fires once per crossing. A sample that stays on the same side of a threshold records nothing. The first sample accepted after the run bit is set never records an event.
- R4: In split mode (SHARED_PEND=0), writing 1 to a bit at 0x78 clears the pending bit with that index, writing 0 changes nothing, and writes to 0x74 are ignored. In shared mode (SHARED_PEND=1), writing 1 to a bit at 0x74 clears that bit and writes to 0x78 are ignored. In both modes, 0x74 reads the pending bits.
- R5: With SPARSE=1, rise event n sits at bit 4n and fall event n at bit 16+4n (up to 4 each). With SPARSE=0, rise event n sits at bit n and fall event n at bit 16+n (up to 8 each). The enable register at 0x70 uses the same bit indices.
- R6: If an event sets a pending bit in the same cycle that a clear write targets it, the bit ends up set.
- R7: `irq` is high exactly when some pending bit is also set in the enable register. Pending bits are recorded even when their enable bit is 0.
- R8: After reset the following hold. Rise threshold n reads 0x40+16n and fall threshold n reads 0x3A+16n. The run bit, interval, enable and pending registers read 0. `irq` is low and the idle flag is 1.
- R9: The run bit is bit 0 of 0x00. While it is 0, samples are ignored and bit 0 of 0x04 reads 1. While it is 1, bit 0 of 0x04 reads 0.
- R10: With interval I at 0x08, the first valid sample after starting is accepted. After each accepted sample, the next I valid samples are skipped.
- R11: Rise threshold n is read and written at 0x10+4n and fall threshold n at 0x30+4n, in the low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| temp_valid | input | 1 | Temperature sample strobe |
| temp_code | input | TEMP_W | Unsigned temperature code |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds two instances side by side and drives both from the same register bus and sample stream. The first uses the defaults: four rise and three fall thresholds, spread layout and a separate clear address. The second uses eight rise and eight fall thresholds, packed layout and one-to-clear on the pending address. This brings both bit layouts and both clear schemes within reach. Because the bus is shared, every clear write tests, on one instance, the address that must act and, on the other, the address that must be ignored.

// File: rtl/thr_pkg.sv
// Shared constants and helper functions for the thermal threshold
// interrupt controller. Assumes a 32-bit register word and an 8-bit
// byte address space.
package thr_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int FALL_BASE = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENG  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IVL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RISE = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FALL = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_EN   = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h78;

    // Bit index of rise event n in the selected layout.
    function automatic int rise_bit(int n, bit sparse);
        return sparse ? 4 * n : n;
    endfunction

    // Bit index of fall event n in the selected layout.
    function automatic int fall_bit(int n, bit sparse);
        return FALL_BASE + (sparse ? 4 * n : n);
    endfunction

    // Mask of every bit that can hold an event.
    function automatic logic [REG_W-1:0] legal_mask(int nr, int nf, bit sparse);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < nr; i++) m[rise_bit(i, sparse)] = 1'b1;
        for (int i = 0; i < nf; i++) m[fall_bit(i, sparse)] = 1'b1;
        return m;
    endfunction

    // Reset value of rise threshold n.
    function automatic logic [7:0] rise_default(int n);
        return 8'(8'h40 + 16 * n);
    endfunction

    // Reset value of fall threshold n (below the matching rise level).
    function automatic logic [7:0] fall_default(int n);
        return 8'(8'h3A + 16 * n);
    endfunction

endpackage

// File: rtl/thr_sampler.sv
// Sample gate: decides which valid samples are accepted for comparison
// (run bit and decimation interval) and keeps the previous accepted
// sample. Assumes temp_code is stable while temp_valid is high.
module thr_sampler #(
    parameter int TEMP_W = 8,
    parameter int IVL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [IVL_W-1:0]  interval,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              accept,
    output logic [TEMP_W-1:0] cur,
    output logic [TEMP_W-1:0] prev,
    output logic              have_prev
);

    logic [IVL_W-1:0] skip_cnt;

    // Accept a sample when running, valid and no skips remain.
    assign accept = run && temp_valid && (skip_cnt == '0);
    assign cur    = temp_code;

    // Skip counter: reload on accept, count down on skipped samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            skip_cnt <= '0;
        end else if (accept) begin
            skip_cnt <= interval;
        end else if (temp_valid) begin
            skip_cnt <= skip_cnt - 1'b1;
        end
    end

    // Previous-sample register, emptied whenever sensing stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev      <= '0;
            have_prev <= 1'b0;
        end else if (!run) begin
            have_prev <= 1'b0;
        end else if (accept) begin
            prev      <= cur;
            have_prev <= 1'b1;
        end
    end

    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (have_prev && prev == $past(cur)));                  // R1
    AST_SKIP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && interval != '0) |=> !accept);                        // R10

endmodule

// File: rtl/thr_detect.sv
// Crossing detector: compares the accepted sample and the previous one
// against every threshold and places each crossing at its layout bit.
// Assumes have_prev is low for the first sample after a start.
module thr_detect
    import thr_pkg::*;
#(
    parameter int NUM_RISE = 4,
    parameter int NUM_FALL = 3,
    parameter bit SPARSE   = 1'b1,
    parameter int TEMP_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              accept,
    input  logic                              have_prev,
    input  logic [TEMP_W-1:0]                 cur,
    input  logic [TEMP_W-1:0]                 prev,
    input  logic [NUM_RISE-1:0][TEMP_W-1:0]   rise_th,
    input  logic [NUM_FALL-1:0][TEMP_W-1:0]   fall_th,
    output logic [REG_W-1:0]                  events
);

    localparam logic [REG_W-1:0] LEGAL = legal_mask(NUM_RISE, NUM_FALL, SPARSE);

    logic [NUM_RISE-1:0] rise_hit;
    logic [NUM_FALL-1:0] fall_hit;
    logic                live;

    assign live = accept && have_prev;

    // One comparator pair per rise threshold.
    for (genvar i = 0; i < NUM_RISE; i++) begin : g_rise
        assign rise_hit[i] = (prev <= rise_th[i]) && (cur > rise_th[i]);
    end

    // One comparator pair per fall threshold.
    for (genvar i = 0; i < NUM_FALL; i++) begin : g_fall
        assign fall_hit[i] = (prev >= fall_th[i]) && (cur < fall_th[i]);
    end

    // Map crossings onto the event word in the chosen layout.
    always_comb begin
        events = '0;
        for (int i = 0; i < NUM_RISE; i++)
            events[rise_bit(i, SPARSE)] = live && rise_hit[i];
        for (int i = 0; i < NUM_FALL; i++)
            events[fall_bit(i, SPARSE)] = live && fall_hit[i];
    end

    AST_EVENT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (events != '0) |-> (accept && have_prev));                      // R3
    AST_EVENT_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (events & ~LEGAL) == '0);                                       // R5

endmodule

// File: rtl/thr_pending.sv
// Pending register: latches events, clears on write-one, set beats
// clear, and forms the masked interrupt. Assumes set and clr are
// single-cycle masks.
module thr_pending #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] enable,
    output logic [W-1:0] status,
    output logic         irq
);

    // Pending bits: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | set;
    end

    // Combined interrupt from enabled pending bits.
    assign irq = |(status & enable);

    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set) != '0) |=> ((status & $past(clr & ~set)) == '0)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((status & $past(set)) == $past(set)));         // R6
    AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(set)) == '0));      // R1

endmodule

// File: rtl/thr_irq_ctrl.sv
// Thermal threshold interrupt controller top: register file, sample
// gate, crossing detector and pending logic. Assumes SPARSE layouts
// use at most 4 thresholds per direction and packed ones at most 8.
module thr_irq_ctrl
    import thr_pkg::*;
#(
    parameter int NUM_RISE    = 4,
    parameter int NUM_FALL    = 3,
    parameter bit SPARSE      = 1'b1,
    parameter bit SHARED_PEND = 1'b0,
    parameter int TEMP_W      = 8,
    parameter int IVL_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] CLR_ADDR = SHARED_PEND ? OFS_STAT : OFS_CLR;

    logic                            run;
    logic [IVL_W-1:0]                interval;
    logic [REG_W-1:0]                enable;
    logic [NUM_RISE-1:0][TEMP_W-1:0] rise_th;
    logic [NUM_FALL-1:0][TEMP_W-1:0] fall_th;
    logic [REG_W-1:0]                status;
    logic [REG_W-1:0]                events;
    logic [REG_W-1:0]                clr_mask;
    logic                            accept;
    logic                            have_prev;
    logic [TEMP_W-1:0]               cur;
    logic [TEMP_W-1:0]               prev;

    // Control, interval and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            interval <= '0;
            enable   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_CTRL) run      <= reg_wdata[0];
            if (reg_addr == OFS_IVL)  interval <= reg_wdata[IVL_W-1:0];
            if (reg_addr == OFS_EN)   enable   <= reg_wdata;
        end
    end

    // Threshold registers with their hysteresis defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RISE; i++) rise_th[i] <= TEMP_W'(rise_default(i));
            for (int i = 0; i < NUM_FALL; i++) fall_th[i] <= TEMP_W'(fall_default(i));
        end else if (reg_wr) begin
            for (int i = 0; i < NUM_RISE; i++)
                if (reg_addr == 8'(OFS_RISE + 4 * i)) rise_th[i] <= reg_wdata[TEMP_W-1:0];
            for (int i = 0; i < NUM_FALL; i++)
                if (reg_addr == 8'(OFS_FALL + 4 * i)) fall_th[i] <= reg_wdata[TEMP_W-1:0];
        end
    end

    // Clear mask from the address chosen by the pending mode.
    assign clr_mask = (reg_wr && reg_addr == CLR_ADDR) ? reg_wdata : '0;

    // Combinational read mux.
    always_comb begin
        case (reg_addr)
            OFS_CTRL: reg_rdata = {31'b0, run};
            OFS_ENG:  reg_rdata = {31'b0, !run};
            OFS_IVL:  reg_rdata = 32'(interval);
            OFS_EN:   reg_rdata = enable;
            OFS_STAT: reg_rdata = status;
            default:  reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_RISE; i++)
            if (reg_addr == 8'(OFS_RISE + 4 * i)) reg_rdata = 32'(rise_th[i]);
        for (int i = 0; i < NUM_FALL; i++)
            if (reg_addr == 8'(OFS_FALL + 4 * i)) reg_rdata = 32'(fall_th[i]);
    end

    thr_sampler #(.TEMP_W(TEMP_W), .IVL_W(IVL_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .run(run), .interval(interval),
        .temp_valid(temp_valid), .temp_code(temp_code),
        .accept(accept), .cur(cur), .prev(prev), .have_prev(have_prev)
    );

    thr_detect #(.NUM_RISE(NUM_RISE), .NUM_FALL(NUM_FALL), .SPARSE(SPARSE),
                 .TEMP_W(TEMP_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .accept(accept), .have_prev(have_prev),
        .cur(cur), .prev(prev), .rise_th(rise_th), .fall_th(fall_th),
        .events(events)
    );

    thr_pending #(.W(REG_W)) u_pending (
        .clk(clk), .rst_n(rst_n), .set(events), .clr(clr_mask),
        .enable(enable), .status(status), .irq(irq)
    );

    AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && reg_addr == OFS_ENG) |-> !accept);             // R9

endmodule

// File: tb/tb_thr_irq_ctrl.sv
module tb_thr_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        temp_valid = 1'b0;
    logic [7:0]  temp_code = '0;
    logic [31:0] rd_a, rd_b;
    logic        irq_a, irq_b;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    thr_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_a), .temp_valid(temp_valid),
        .temp_code(temp_code), .irq(irq_a)
    );

    thr_irq_ctrl #(.NUM_RISE(8), .NUM_FALL(8), .SPARSE(1'b0), .SHARED_PEND(1'b1)) dut_w (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_b), .temp_valid(temp_valid),
        .temp_code(temp_code), .irq(irq_b)
    );

    // {sample, expected pending spread/split, expected pending packed/shared}
    localparam logic [71:0] VEC [7] = '{
        {8'h30, 32'h0000_0000, 32'h0000_0000},
        {8'h41, 32'h0000_0001, 32'h0000_0001},
        {8'h45, 32'h0000_0001, 32'h0000_0001},
        {8'h40, 32'h0000_0001, 32'h0000_0001},
        {8'h75, 32'h0000_1111, 32'h0000_000F},
        {8'h59, 32'h0100_1111, 32'h000C_000F},
        {8'h39, 32'h0111_1111, 32'h000F_000F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] va, output logic [31:0] vb);
        reg_addr = a;
        #1;
        va = rd_a; vb = rd_b;
    endtask

    task automatic smp(input logic [7:0] t);
        @(negedge clk);
        temp_code = t; temp_valid = 1'b1;
        @(negedge clk);
        temp_valid = 1'b0;
    endtask

    task automatic expect_pend(input string req, input logic [31:0] ea, input logic [31:0] eb);
        logic [31:0] va, vb;
        rd(8'h74, va, vb);
        chk({req, " spread"}, va, ea);
        chk({req, " packed"}, vb, eb);
    endtask

    task automatic clear_all();
        wr(8'h78, 32'hFFFF_FFFF);
        wr(8'h74, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] va, vb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h10 + 4 * i), va, vb);
            chk("R8 rise default", va, 32'(8'h40 + 16 * i));
            chk("R8 rise default w", vb, 32'(8'h40 + 16 * i));
        end
        for (int i = 0; i < 3; i++) begin
            rd(8'(8'h30 + 4 * i), va, vb);
            chk("R8 fall default", va, 32'(8'h3A + 16 * i));
        end
        rd(8'h70, va, vb); chk("R8 enable", va, 0);
        rd(8'h00, va, vb); chk("R8 control", va, 0);
        rd(8'h08, va, vb); chk("R8 interval", vb, 0);
        rd(8'h04, va, vb); chk("R8 idle", va, 1);
        expect_pend("R8 pending", 0, 0);
        chk("R8 irq", {30'b0, irq_a, irq_b}, 0);

        // R9 start
        wr(8'h00, 1);
        rd(8'h04, va, vb); chk("R9 busy", va, 0);

        // R1 R2 R5 table walk
        for (int k = 0; k < 7; k++) begin
            smp(VEC[k][71:64]);
            expect_pend("R1/R2/R5 table", VEC[k][63:32], VEC[k][31:0]);
        end
        chk("R7 masked irq", {31'b0, irq_a}, 0);

        // R4 clear paths
        wr(8'h78, 32'h1);
        expect_pend("R4 clear addr", 32'h0111_1110, 32'h000F_000F);
        wr(8'h74, 32'h0001_0000);
        expect_pend("R4 pend addr", 32'h0111_1110, 32'h000E_000F);
        wr(8'h78, 32'h0);
        expect_pend("R4 zero write", 32'h0111_1110, 32'h000E_000F);

        // R7 enable masks irq only
        wr(8'h70, 32'h10);
        chk("R7 irq on", {31'b0, irq_a}, 1);
        chk("R7 irq off", {31'b0, irq_b}, 0);

        // R3 no re-fire while staying below
        smp(8'h39);
        expect_pend("R3 hold", 32'h0111_1110, 32'h000E_000F);
        clear_all();
        expect_pend("R4 clear all", 0, 0);
        chk("R7 irq drop", {31'b0, irq_a}, 0);
        smp(8'h38);
        expect_pend("R3 no crossing", 0, 0);
        smp(8'h41);
        expect_pend("R1 rise0", 1, 1);

        // R6 set beats clear in the same cycle
        @(negedge clk);
        temp_code = 8'h30; temp_valid = 1'b1;
        reg_addr = 8'h78; reg_wdata = 32'h0001_0001; reg_wr = 1'b1;
        @(negedge clk);
        temp_valid = 1'b0; reg_wr = 1'b0;
        expect_pend("R6 set wins", 32'h0001_0000, 32'h0001_0001);

        // R10 decimation interval
        clear_all();
        wr(8'h08, 2);
        smp(8'h41); expect_pend("R10 accepted", 1, 1);
        smp(8'h30); expect_pend("R10 skip1", 1, 1);
        smp(8'h30); expect_pend("R10 skip2", 1, 1);
        smp(8'h30); expect_pend("R10 next", 32'h0001_0001, 32'h0001_0001);
        wr(8'h08, 0);

        // R9 stopped engine ignores samples
        wr(8'h00, 0);
        rd(8'h04, va, vb); chk("R9 idle", va, 1);
        clear_all();
        smp(8'h75);
        expect_pend("R9 ignored", 0, 0);

        // R3 first sample after restart, then R2 falls
        wr(8'h00, 1);
        smp(8'h75);
        expect_pend("R3 first sample", 0, 0);
        smp(8'h30);
        expect_pend("R2 falls", 32'h0111_0000, 32'h000F_0000);

        // R11 threshold write
        wr(8'h10, 32'h20);
        rd(8'h10, va, vb);
        chk("R11 rise0", va, 32'h20);
        chk("R11 rise0 w", vb, 32'h20);
        wr(8'h34, 32'h11);
        rd(8'h34, va, vb);
        chk("R11 fall1", va, 32'h11);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule